// File: doc/BRIEF.md
# Light-Load Sleep Detector for a Synchronous-Rectifier Driver

This block decides, one half-switching period at a time, whether the gate driver of a synchronous rectifier should keep switching or go quiet. It times the low phase of a digital clock-pulse input as the half-period. It times the rectifier conduction from a comparator that reports that the drain-source voltage is below the turn-on level. When the rectifier has little work to do, the conduction fraction falls. If it stays below a programmable entry threshold for a programmable run of periods, the block raises its sleep flag and drops gate enable. A single period whose fraction reaches a higher exit threshold brings gating back.

The end of a conduction interval depends on the mode. While gating is active, the interval closes when the gate-drive command falls. While asleep, no gate pulse exists, so the interval closes when the comparator releases. One duty measurement therefore serves both modes. The block also watches the half-period length. A half-period longer than a programmed limit means deep below-resonance operation. A saturated period counter means the same thing. Either one withholds gate enable at once, even before the period has ended.

The block samples all inputs on the system clock, so each rising or falling input edge is seen one sample after it happens. Both outputs are registered.

Top module: `sr_sleep_detect`

## Requirements
- R1: While reset is held, and after it is released until a decision changes it, sleep_o is 1 and gate_en_o is 0.
- R2: The half-period count is the number of clock samples in which pulse_i was 0, from the sample that sees it fall to the sample that sees it rise. The sample that sees the rise is the evaluation sample, but only if a fall was seen earlier. Both outputs take their new value at that clock edge.
- R3: In active mode (sleep_o=0), the conduction count covers the sample that sees vds_low_i rise and every later sample up to, but not including, the sample that sees gate_cmd_i fall.
- R4: In sleep mode (sleep_o=1), the conduction count runs from the rise of vds_low_i until the sample in which vds_low_i is 0. gate_cmd_i has no effect.
- R5: An evaluation is low when cond × 2^FRAC_W < d_off_i × period. This comparison is strict. In active mode, enter_cycles_i consecutive low evaluations set sleep_o=1 and gate_en_o=0. A value of 0 in enter_cycles_i counts as 1.
- R6: In active mode, a non-low evaluation resets the run of low evaluations. This includes the case cond × 2^FRAC_W equal to d_off_i × period.
- R7: In sleep mode, a single evaluation with cond × 2^FRAC_W ≥ d_on_i × period clears sleep_o and raises gate_en_o. Equality wakes the block.
- R8: An evaluation whose period exceeds period_max_i forces gate_en_o=0. It leaves sleep_o unchanged and clears the run of low evaluations. The next evaluation with a period within the limit removes the block.
- R9: While a period is still being timed, gate_en_o falls at the first edge after the running count exceeds period_max_i. The block does not wait for the period to end.
- R10: Both counters saturate at 2^CNT_W−1. A saturated period count is treated as over the limit whatever period_max_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Digital clock pulse; its low phase is the half-period |
| vds_low_i | input | 1 | Comparator: drain-source voltage below turn-on level |
| gate_cmd_i | input | 1 | Gate-drive command from the turn-off logic |
| d_off_i | input | FRAC_W | Sleep entry duty threshold, fraction of 2^FRAC_W |
| d_on_i | input | FRAC_W | Wake-up duty threshold, fraction of 2^FRAC_W |
| enter_cycles_i | input | QUAL_W | Consecutive low periods needed to sleep |
| period_max_i | input | CNT_W | Longest half-period allowed before gating is blocked |
| sleep_o | output | 1 | Sleep flag |
| gate_en_o | output | 1 | Gate driving permitted |

## Verification
The evaluation at the end of a period can land in the same cycle as the below-resonance test. Long periods carrying a low conduction fraction provoke this. They are judged by checking that gating is blocked while sleep_o holds, and that the low run does not advance. Conduction edges can also coincide with the period boundary. The bench runs vds_low_i through the boundary, so the count must restart at 1 in the next period and not be lost. A behavioural reference model is stepped on every clock and compared with both outputs. The bench also checks fixed expected values after each scenario, including both equality boundaries.

// File: rtl/sr_sleep_pkg.sv
`timescale 1ns/1ps
package sr_sleep_pkg;
  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_SLEEP  = 1'b1
  } sr_mode_e;
endpackage

// File: rtl/sr_period_timer.sv
`timescale 1ns/1ps
module sr_period_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] per_cnt_o,
  output logic             measuring_o,
  output logic             cyc_end_o,
  output logic             eval_o
);
  localparam logic [CNT_W-1:0] PMAX = {CNT_W{1'b1}};

  logic pulse_q;
  logic fall;

  assign fall      = !pulse_i && pulse_q;
  assign cyc_end_o = pulse_i && !pulse_q;
  assign eval_o    = cyc_end_o && measuring_o;

  // R2 low-phase timing, R10 saturation
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q     <= 1'b0;
      per_cnt_o   <= '0;
      measuring_o <= 1'b0;
    end else begin
      pulse_q <= pulse_i;
      if (fall) begin
        per_cnt_o   <= CNT_W'(1);
        measuring_o <= 1'b1;
      end else if (cyc_end_o) begin
        measuring_o <= 1'b0;
      end else if (measuring_o && per_cnt_o != PMAX) begin
        per_cnt_o <= per_cnt_o + CNT_W'(1);
      end
    end
  end

  // R10
  per_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (measuring_o && per_cnt_o == PMAX && !pulse_i) |=> (per_cnt_o == PMAX));
endmodule

// File: rtl/sr_conduction_timer.sv
`timescale 1ns/1ps
module sr_conduction_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vds_low_i,
  input  logic             gate_cmd_i,
  input  logic             asleep_i,
  input  logic             cyc_end_i,
  output logic [CNT_W-1:0] cond_cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic vds_q, gate_q, on_q;
  logic start, stop, inc;

  // R3 ends at gate fall while active; R4 ends at comparator release while asleep
  assign start = vds_low_i && !vds_q;
  assign stop  = asleep_i ? !vds_low_i : (!gate_cmd_i && gate_q);
  assign inc   = start || (on_q && !stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      vds_q      <= 1'b0;
      gate_q     <= 1'b0;
      on_q       <= 1'b0;
      cond_cnt_o <= '0;
    end else begin
      vds_q  <= vds_low_i;
      gate_q <= gate_cmd_i;
      on_q   <= inc;
      if (cyc_end_i) begin
        cond_cnt_o <= inc ? CNT_W'(1) : '0;
      end else if (inc && cond_cnt_o != CMAX) begin
        cond_cnt_o <= cond_cnt_o + CNT_W'(1);
      end
    end
  end

  // R10 count only grows (saturating) between period boundaries
  cond_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_end_i |=> (cond_cnt_o >= $past(cond_cnt_o)));
endmodule

// File: rtl/sr_duty_cmp.sv
`timescale 1ns/1ps
module sr_duty_cmp #(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic [CNT_W-1:0]  cond_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic [FRAC_W-1:0] thr_i,
  output logic              below_o
);
  localparam int PW = CNT_W + FRAC_W;

  logic [PW-1:0] lhs, rhs;

  // R5 scaled comparison, no divider
  assign lhs     = {cond_i, {FRAC_W{1'b0}}};
  assign rhs     = PW'(thr_i) * PW'(per_i);
  assign below_o = lhs < rhs;
endmodule

// File: rtl/sr_sleep_fsm.sv
`timescale 1ns/1ps
module sr_sleep_fsm
  import sr_sleep_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic              measuring_i,
  input  logic [CNT_W-1:0]  per_cnt_i,
  input  logic [CNT_W-1:0]  period_max_i,
  input  logic [QUAL_W-1:0] enter_cycles_i,
  input  logic              low_hit_i,
  input  logic              high_hit_i,
  output logic              sleep_o,
  output logic              gate_en_o
);
  localparam logic [CNT_W-1:0] PMAX = {CNT_W{1'b1}};

  sr_mode_e          mode_q, mode_n;
  logic              deep_q, deep_n;
  logic [QUAL_W-1:0] streak_q, streak_n;
  logic [QUAL_W-1:0] need;
  logic [QUAL_W:0]   streak_p1;
  logic              over;
  logic              gate_q;

  // R8 R10 over-limit period
  assign over      = (per_cnt_i == PMAX) || (per_cnt_i > period_max_i);
  assign need      = (enter_cycles_i == '0) ? QUAL_W'(1) : enter_cycles_i;
  assign streak_p1 = {1'b0, streak_q} + (QUAL_W+1)'(1);

  always_comb begin
    mode_n   = mode_q;
    deep_n   = deep_q;
    streak_n = streak_q;
    if (eval_i) begin
      if (over) begin
        deep_n   = 1'b1;
        streak_n = '0;
      end else begin
        deep_n = 1'b0;
        if (mode_q == MODE_SLEEP) begin
          if (high_hit_i) mode_n = MODE_ACTIVE;
          streak_n = '0;
        end else if (low_hit_i) begin
          if (streak_p1 >= {1'b0, need}) begin
            mode_n   = MODE_SLEEP;
            streak_n = '0;
          end else begin
            streak_n = streak_p1[QUAL_W-1:0];
          end
        end else begin
          streak_n = '0;
        end
      end
    end else if (measuring_i && over) begin
      deep_n = 1'b1;
    end
  end

  // R1 reset into sleep
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_SLEEP;
      deep_q   <= 1'b0;
      streak_q <= '0;
      gate_q   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      deep_q   <= deep_n;
      streak_q <= streak_n;
      gate_q   <= (mode_n == MODE_ACTIVE) && !deep_n;
    end
  end

  assign sleep_o   = (mode_q == MODE_SLEEP);
  assign gate_en_o = gate_q;

  // R5
  enter_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(eval_i && low_hit_i));
  // R7
  wake_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_o) |-> $past(eval_i && high_hit_i));
  // R9
  mid_block_chk: assert property (@(posedge clk) disable iff (rst)
    (measuring_i && !eval_i && over) |=> !gate_en_o);
endmodule

// File: rtl/sr_sleep_detect.sv
`timescale 1ns/1ps
module sr_sleep_detect #(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 8,
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_i,
  input  logic              vds_low_i,
  input  logic              gate_cmd_i,
  input  logic [FRAC_W-1:0] d_off_i,
  input  logic [FRAC_W-1:0] d_on_i,
  input  logic [QUAL_W-1:0] enter_cycles_i,
  input  logic [CNT_W-1:0]  period_max_i,
  output logic              sleep_o,
  output logic              gate_en_o
);
  localparam int NTHR = 2;

  logic [CNT_W-1:0]  per_cnt, cond_cnt;
  logic              measuring, cyc_end, eval;
  logic [NTHR-1:0]   below;
  logic [FRAC_W-1:0] thr [NTHR];

  assign thr[0] = d_off_i;
  assign thr[1] = d_on_i;

  sr_period_timer #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst(rst), .pulse_i(pulse_i),
    .per_cnt_o(per_cnt), .measuring_o(measuring),
    .cyc_end_o(cyc_end), .eval_o(eval)
  );

  sr_conduction_timer #(.CNT_W(CNT_W)) u_cond (
    .clk(clk), .rst(rst), .vds_low_i(vds_low_i), .gate_cmd_i(gate_cmd_i),
    .asleep_i(sleep_o), .cyc_end_i(cyc_end), .cond_cnt_o(cond_cnt)
  );

  for (genvar gi = 0; gi < NTHR; gi++) begin : g_cmp
    sr_duty_cmp #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_cmp (
      .cond_i(cond_cnt), .per_i(per_cnt), .thr_i(thr[gi]), .below_o(below[gi])
    );
  end

  sr_sleep_fsm #(.CNT_W(CNT_W), .QUAL_W(QUAL_W)) u_fsm (
    .clk(clk), .rst(rst), .eval_i(eval), .measuring_i(measuring),
    .per_cnt_i(per_cnt), .period_max_i(period_max_i),
    .enter_cycles_i(enter_cycles_i),
    .low_hit_i(below[0]), .high_hit_i(!below[1]),
    .sleep_o(sleep_o), .gate_en_o(gate_en_o)
  );
endmodule

// File: tb/sr_sleep_detect_bench.sv
`timescale 1ns/1ps
module sr_sleep_detect_bench;
  localparam int CW = 12, FW = 8, QW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic p = 1'b1, v = 1'b0, g = 1'b0;
  logic [FW-1:0] d_off = 8'd64, d_on = 8'd128;
  logic [QW-1:0] enter = 4'd3;
  logic [CW-1:0] lim = 12'd50;
  logic sleep_o, gate_en_o;

  int total = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic probe_val;

  always #10 clk = ~clk;

  sr_sleep_detect #(.CNT_W(CW), .FRAC_W(FW), .QUAL_W(QW)) u_sr_sleep_detect (
    .clk(clk), .rst(rst), .pulse_i(p), .vds_low_i(v), .gate_cmd_i(g),
    .d_off_i(d_off), .d_on_i(d_on), .enter_cycles_i(enter),
    .period_max_i(lim), .sleep_o(sleep_o), .gate_en_o(gate_en_o)
  );

  // behavioural reference model
  int m_pq, m_vq, m_gq, m_meas, m_per, m_cond, m_con, m_sleep, m_deep, m_gate, m_streak;
  always @(posedge clk) begin
    int fall, rise, start, stop, inc, over, ev, need;
    if (rst) begin
      m_pq = 0; m_vq = 0; m_gq = 0; m_meas = 0; m_per = 0; m_cond = 0; m_con = 0;
      m_sleep = 1; m_deep = 0; m_gate = 0; m_streak = 0;
    end else begin
      fall  = (!p && m_pq) ? 1 : 0;
      rise  = (p && !m_pq) ? 1 : 0;
      start = (v && !m_vq) ? 1 : 0;
      stop  = m_sleep ? (v ? 0 : 1) : ((!g && m_gq) ? 1 : 0);
      inc   = (start || (m_con && !stop)) ? 1 : 0;
      over  = (m_per == MAXC || m_per > int'(lim)) ? 1 : 0;
      ev    = rise && m_meas;
      need  = (enter == 0) ? 1 : int'(enter);
      if (ev) begin
        if (over) begin m_deep = 1; m_streak = 0; end
        else begin
          m_deep = 0;
          if (m_sleep) begin
            if (m_cond * 256 >= int'(d_on) * m_per) m_sleep = 0;
            m_streak = 0;
          end else if (m_cond * 256 < int'(d_off) * m_per) begin
            if (m_streak + 1 >= need) begin m_sleep = 1; m_streak = 0; end
            else m_streak++;
          end else m_streak = 0;
        end
      end else if (m_meas && over) m_deep = 1;
      if (rise) m_cond = inc; else if (inc && m_cond < MAXC) m_cond++;
      m_con = inc;
      if (fall) begin m_per = 1; m_meas = 1; end
      else if (rise) m_meas = 0;
      else if (m_meas && m_per < MAXC) m_per++;
      m_pq = p; m_vq = v; m_gq = g;
      m_gate = (!m_sleep && !m_deep) ? 1 : 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "sleep_o vs model", sleep_o, m_sleep[0]);
      chk(cur_req, "gate_en_o vs model", gate_en_o, m_gate[0]);
    end
  end

  // one half-switching cycle: low phase lo, high phase hi; v and g windows by sample index
  task automatic cycle(int lo, int hi, int va, int vl, int ga, int gl, int probe = -1);
    for (int i = 0; i < lo + hi; i++) begin
      @(negedge clk);
      if (i == probe) probe_val = gate_en_o;
      p = (i < lo) ? 1'b0 : 1'b1;
      v = (i >= va && i < va + vl) ? 1'b1 : 1'b0;
      g = (i >= ga && i < ga + gl) ? 1'b1 : 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog R2: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "sleep_o in reset", sleep_o, 1'b1);
    chk("R1", "gate_en_o in reset", gate_en_o, 1'b0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "sleep_o after reset", sleep_o, 1'b1);
    chk("R1", "gate_en_o after reset", gate_en_o, 1'b0);

    // R7 wake from sleep, R4 conduction closes on comparator release
    cur_req = "R7";
    cycle(40, 4, 2, 30, 3, 25);
    chk("R7", "sleep_o after high duty", sleep_o, 1'b0);
    chk("R7", "gate_en_o after high duty", gate_en_o, 1'b1);
    cur_req = "R2";
    cycle(40, 4, 2, 30, 3, 25);
    chk("R2", "stays active", sleep_o, 1'b0);

    // R3 active conduction closes on gate fall (comparator stays long)
    cur_req = "R3";
    cycle(40, 4, 2, 35, 3, 6);
    chk("R3", "one low cycle no sleep", sleep_o, 1'b0);
    cur_req = "R6";
    cycle(40, 4, 2, 35, 3, 6);
    cycle(40, 4, 2, 35, 3, 9);  // cond == d_off boundary: not low
    chk("R6", "equality breaks run", sleep_o, 1'b0);
    cycle(40, 4, 2, 35, 3, 6);
    cycle(40, 4, 2, 35, 3, 6);
    chk("R6", "two lows after reset of run", sleep_o, 1'b0);
    cur_req = "R5";
    cycle(40, 4, 2, 35, 3, 6);
    chk("R5", "third low enters sleep", sleep_o, 1'b1);
    chk("R5", "gate blocked in sleep", gate_en_o, 1'b0);

    // R4 in sleep, long gate command has no effect
    cur_req = "R4";
    cycle(40, 4, 2, 5, 3, 30);
    chk("R4", "short diode conduction keeps sleep", sleep_o, 1'b1);
    cycle(40, 4, 2, 20, 3, 2);  // cond*256 == d_on*per: wakes
    chk("R7", "equality wakes", sleep_o, 1'b0);
    chk("R7", "gate back", gate_en_o, 1'b1);

    // R8 and R9 long periods
    cur_req = "R9";
    cycle(60, 4, 2, 50, 3, 50, 58);
    chk("R9", "gate dropped mid-period", probe_val, 1'b0);
    cur_req = "R8";
    chk("R8", "gate blocked after long period", gate_en_o, 1'b0);
    cycle(60, 4, 2, 4, 3, 2);
    cycle(60, 4, 2, 4, 3, 2);
    cycle(60, 4, 2, 4, 3, 2);
    chk("R8", "low long periods do not sleep", sleep_o, 1'b0);
    cycle(40, 4, 2, 30, 3, 25);
    chk("R8", "normal period restores gate", gate_en_o, 1'b1);
    cycle(40, 4, 2, 35, 3, 6);
    cycle(40, 4, 2, 35, 3, 6);
    chk("R8", "run cleared by long periods", sleep_o, 1'b0);

    // R10 saturation, limit at full scale
    cur_req = "R10";
    lim = 12'hFFF;
    cycle(4200, 4, 2, 30, 3, 25, 4150);
    chk("R10", "saturated period blocks mid-period", probe_val, 1'b0);
    chk("R10", "saturated period blocks gate", gate_en_o, 1'b0);
    cycle(40, 4, 2, 30, 3, 25);
    chk("R10", "gate restored", gate_en_o, 1'b1);

    // R5 enter_cycles 0 acts as 1
    cur_req = "R5";
    enter = 4'd0;
    cycle(40, 4, 2, 35, 3, 6);
    chk("R5", "single low enters sleep", sleep_o, 1'b1);

    // R10 conduction saturation while asleep
    cur_req = "R10";
    cycle(4300, 4, 0, 4302, 3, 2);
    chk("R10", "sleep held over saturated period", sleep_o, 1'b1);
    lim = 12'd50;
    cycle(40, 4, 2, 30, 3, 25);
    chk("R10", "recovery after saturation", sleep_o, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule